// File: doc/BRIEF.md
# Paired DC-Only Block Reconstruction

This block rebuilds the pixels of two side-by-side 4x4 blocks whose only nonzero transform coefficient is the DC term. For such blocks the inverse transform reduces to a constant. The block scales each DC coefficient by a shared dequantization factor, rounds the result to a single signed offset per block, adds that offset to every prediction pixel of the block, and clamps each sum to the 8-bit pixel range.

A transaction carries the two DC coefficients, the dequantization factor and the 32 prediction bytes of a 4-row by 8-column area, and is handed over with a valid/ready handshake. The reconstructed bytes come back two cycles later on an output held under its own valid/ready handshake. When a pair is taken in, the block raises a one-cycle strobe per coefficient slot. The surrounding decoder uses that strobe to zero the consumed DC slots in its coefficient store.

Control is a three-state machine. `S_IDLE` waits for a pair. `S_LOAD` is the cycle in which the captured offsets and prediction bytes pass through the add-and-clamp lanes. `S_PRESENT` holds the result on the output. The transitions are:
- `S_IDLE` to `S_LOAD` on an accepted pair.
- `S_LOAD` to `S_PRESENT` unconditionally.
- `S_PRESENT` to `S_IDLE` when the result is taken and no new pair arrives.
- `S_PRESENT` to `S_LOAD` when the result is taken and a new pair is accepted in the same cycle.
- `S_PRESENT` to itself while the output is stalled.

Top module: `dcr_pair_top`

## Requirements
- R1: For block b the offset is computed as follows. Multiply the coefficient `dc_coef[16b+15:16b]` and `dq`, both read as signed 16-bit values, into a full signed product. Add 4 to the product. Shift the sum right by 3 arithmetically. Keep the low 16 bits of the result as a signed value. A zero `dq` therefore leaves the prediction unchanged.
- R2: Pixel p, where p = row*8 + column with rows 0..3 and columns 0..7, occupies bits [8p+7:8p] of both `pred` and `recon`. Columns 0..3 use the offset of slot 0, the left block. Columns 4..7 use the offset of slot 1, the right block.
- R3: Each output byte is the unsigned prediction byte plus the block offset, clamped to 0 when the sum is negative and to 255 when it exceeds 255.
- R4: A pair is accepted on a rising edge where `in_valid` and `in_ready` are both high. `out_valid` rises two rising edges later.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `recon` keeps its value.
- R6: `in_ready` is high in `S_IDLE`. It is also high in `S_PRESENT` in a cycle where `out_ready` is high. It is low in every other cycle, including the cycle right after an accept and every stalled output cycle.
- R7: `clr_dc` is 2'b11 for exactly the one cycle following an accepted pair, and 2'b00 otherwise. Bit 0 clears the left slot and bit 1 clears the right slot.
- R8: During and right after reset, `out_valid` is low, `in_ready` is high and `clr_dc` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A pair is presented |
| in_ready | output | 1 | The block can take a pair this cycle |
| dc_coef | input | 32 | Signed DC coefficients, slot 0 (left) in bits 15:0, slot 1 (right) in bits 31:16 |
| dq | input | 16 | Signed dequantization factor shared by both blocks |
| pred | input | 256 | 32 prediction bytes, pixel p in bits 8p+7:8p |
| out_valid | output | 1 | Reconstructed bytes are available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| recon | output | 256 | 32 reconstructed bytes, same layout as `pred` |
| clr_dc | output | 2 | One-cycle strobe per slot asking that the DC coefficient be zeroed |

## Verification
Only one pair is in flight at a time, so each result has a fixed place in time. The clear strobe appears in the first cycle after an accept. The reconstructed bytes appear in the second cycle after the accept and stay there until the consumer takes them. The bench keeps a behavioural model that follows the accept, load and present phases using integers and per-pixel arithmetic. Each cycle it drives the inputs just after the falling edge, then compares `in_ready`, `out_valid`, `clr_dc` and, while a result is presented, every output byte against the model. Stalls are injected on both sides. Directed pairs cover the rounding boundary, very large positive and negative offsets, the 16-bit wraparound of the offset, and a zero dequantization factor.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    localparam int DCR_COEF_W   = 16;
    localparam int DCR_PIX_W    = 8;
    localparam int DCR_ROWS     = 4;
    localparam int DCR_BLK_COLS = 4;
    localparam int DCR_NBLK     = 2;
    localparam int DCR_SHIFT    = 3;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_LOAD    = 2'd1,
        S_PRESENT = 2'd2
    } dcr_state_e;

endpackage

// File: rtl/dcr_dc_scale.sv
module dcr_dc_scale #(
    parameter int COEF_W = 16,
    parameter int SHIFT  = 3
) (
    input  logic [COEF_W-1:0] coef,
    input  logic [COEF_W-1:0] dq,
    output logic [COEF_W-1:0] off
);
    localparam int PROD_W = 2 * COEF_W;
    localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (SHIFT - 1);

    logic signed [PROD_W-1:0] coef_x;
    logic signed [PROD_W-1:0] dq_x;
    logic signed [PROD_W-1:0] product;
    logic signed [PROD_W-1:0] biased;
    logic signed [PROD_W-1:0] scaled;

    always_comb begin
        coef_x  = {{COEF_W{coef[COEF_W-1]}}, coef};
        dq_x    = {{COEF_W{dq[COEF_W-1]}}, dq};
        product = coef_x * dq_x;
        biased  = product + HALF;
        scaled  = biased >>> SHIFT;
        off     = scaled[COEF_W-1:0];
    end

endmodule

// File: rtl/dcr_pix_clamp.sv
module dcr_pix_clamp #(
    parameter int PIX_W = 8,
    parameter int OFF_W = 16
) (
    input  logic [PIX_W-1:0] pred_px,
    input  logic [OFF_W-1:0] off,
    output logic [PIX_W-1:0] recon_px
);
    localparam int SUM_W = OFF_W + 2;
    localparam logic signed [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

    logic signed [SUM_W-1:0] pred_x;
    logic signed [SUM_W-1:0] off_x;
    logic signed [SUM_W-1:0] total;

    always_comb begin
        pred_x = {{(SUM_W - PIX_W){1'b0}}, pred_px};
        off_x  = {{2{off[OFF_W-1]}}, off};
        total  = pred_x + off_x;
        if (total < 0) begin
            recon_px = '0;
        end else if (total > PIX_MAX) begin
            recon_px = '1;
        end else begin
            recon_px = total[PIX_W-1:0];
        end
    end

endmodule

// File: rtl/dcr_ctrl.sv
module dcr_ctrl
    import dcr_pkg::*;
#(
    parameter int NBLK = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            out_ready,
    output logic            in_ready,
    output logic            load_in,
    output logic            load_out,
    output logic            out_valid,
    output logic [NBLK-1:0] clr_dc
);
    dcr_state_e state_q;
    dcr_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (in_valid) state_d = S_LOAD;
            S_LOAD:    state_d = S_PRESENT;
            S_PRESENT: if (out_ready) state_d = in_valid ? S_LOAD : S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        in_ready  = 1'b0;
        load_out  = 1'b0;
        out_valid = 1'b0;
        clr_dc    = '0;
        unique case (state_q)
            S_IDLE: begin
                in_ready = 1'b1;
            end
            S_LOAD: begin
                load_out = 1'b1;
                clr_dc   = '1;
            end
            S_PRESENT: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
            end
            default: begin
                in_ready = 1'b0;
            end
        endcase
        load_in = in_valid && in_ready;
    end

endmodule

// File: rtl/dcr_pair_top.sv
module dcr_pair_top
    import dcr_pkg::*;
#(
    parameter int COEF_W   = DCR_COEF_W,
    parameter int PIX_W    = DCR_PIX_W,
    parameter int ROWS     = DCR_ROWS,
    parameter int BLK_COLS = DCR_BLK_COLS,
    parameter int NBLK     = DCR_NBLK,
    parameter int SHIFT    = DCR_SHIFT
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 in_valid,
    output logic                                 in_ready,
    input  logic [NBLK*COEF_W-1:0]               dc_coef,
    input  logic [COEF_W-1:0]                    dq,
    input  logic [ROWS*BLK_COLS*NBLK*PIX_W-1:0]  pred,
    output logic                                 out_valid,
    input  logic                                 out_ready,
    output logic [ROWS*BLK_COLS*NBLK*PIX_W-1:0]  recon,
    output logic [NBLK-1:0]                      clr_dc
);
    localparam int ROW_PIX = BLK_COLS * NBLK;
    localparam int NPIX    = ROWS * ROW_PIX;
    localparam int BUS_W   = NPIX * PIX_W;

    logic              load_in;
    logic              load_out;
    logic [COEF_W-1:0] off_d [NBLK];
    logic [COEF_W-1:0] off_q [NBLK];
    logic [BUS_W-1:0]  pred_q;
    logic [BUS_W-1:0]  recon_d;
    logic [BUS_W-1:0]  recon_q;

    dcr_ctrl #(
        .NBLK(NBLK)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .out_ready(out_ready),
        .in_ready (in_ready),
        .load_in  (load_in),
        .load_out (load_out),
        .out_valid(out_valid),
        .clr_dc   (clr_dc)
    );

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        dcr_dc_scale #(
            .COEF_W(COEF_W),
            .SHIFT (SHIFT)
        ) u_scale (
            .coef(dc_coef[b*COEF_W +: COEF_W]),
            .dq  (dq),
            .off (off_d[b])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBLK; b++) off_q[b] <= '0;
            pred_q <= '0;
        end else if (load_in) begin
            for (int b = 0; b < NBLK; b++) off_q[b] <= off_d[b];
            pred_q <= pred;
        end
    end

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        localparam int COL = p % ROW_PIX;
        localparam int BLK = COL / BLK_COLS;
        dcr_pix_clamp #(
            .PIX_W(PIX_W),
            .OFF_W(COEF_W)
        ) u_lane (
            .pred_px (pred_q[p*PIX_W +: PIX_W]),
            .off     (off_q[BLK]),
            .recon_px(recon_d[p*PIX_W +: PIX_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        recon_q <= '0;
        else if (load_out) recon_q <= recon_d;
    end

    assign recon = recon_q;

endmodule

// File: rtl/dcr_pair_check.sv
module dcr_pair_check #(
    parameter int BUS_W  = 256,
    parameter int COEF_W = 16,
    parameter int NBLK   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [COEF_W-1:0] dq,
    input logic [BUS_W-1:0]  pred,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BUS_W-1:0]  recon,
    input logic [NBLK-1:0]   clr_dc
);
    logic accept;
    assign accept = in_valid && in_ready;

    AST_ZERO_SCALE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dq == '0) |-> ##2 (recon == $past(pred, 2))); // R1

    AST_TWO_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##2 out_valid); // R4

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(recon))); // R5

    AST_NO_ACCEPT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R6

    AST_CLEAR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (clr_dc == '1)); // R7

    AST_CLEAR_ONLY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_dc != '0) |-> $past(accept)); // R7

    AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_dc != '0) |=> (clr_dc == '0)); // R7

endmodule

bind dcr_pair_top dcr_pair_check #(
    .BUS_W (ROWS*BLK_COLS*NBLK*PIX_W),
    .COEF_W(COEF_W),
    .NBLK  (NBLK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .dq       (dq),
    .pred     (pred),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .recon    (recon),
    .clr_dc   (clr_dc)
);

// File: tb/dcr_pair_top_test.sv
`timescale 1ns/1ps
module dcr_pair_top_test;

    localparam int NT = 14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  dc_coef = '0;
    logic [15:0]  dq = '0;
    logic [255:0] pred = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [255:0] recon;
    logic [1:0]   clr_dc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0]  t_coef [NT];
    logic [15:0]  t_dq   [NT];
    logic [255:0] t_pred [NT];

    always #2.5 clk = ~clk;

    dcr_pair_top uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .dc_coef  (dc_coef),
        .dq       (dq),
        .pred     (pred),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .recon    (recon),
        .clr_dc   (clr_dc)
    );

    function automatic logic [255:0] ref_recon(input logic [31:0] cf, input logic [15:0] d,
                                               input logic [255:0] pv);
        logic [255:0] r;
        int ofs [2];
        for (int b = 0; b < 2; b++) begin
            int c, m, prod, sh;
            shortint o;
            c    = int'($signed(cf[b*16 +: 16]));
            m    = int'($signed(d));
            prod = c * m;
            sh   = (prod + 4) >>> 3;
            o    = shortint'(sh);
            ofs[b] = int'(o);
        end
        for (int p = 0; p < 32; p++) begin
            int col, v;
            col = p % 8;
            v = int'(pv[p*8 +: 8]) + ofs[col / 4];
            if (v < 0) v = 0;
            if (v > 255) v = 255;
            r[p*8 +: 8] = v[7:0];
        end
        return r;
    endfunction

    function automatic logic [255:0] ramp(input int base, input int step);
        logic [255:0] r;
        for (int p = 0; p < 32; p++) r[p*8 +: 8] = 8'(base + p * step);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        logic [31:0] lf;
        // R3 extremes: large positive offset gives 255, large negative gives 0
        t_coef[0] = {16'd1000, 16'd1000};        t_dq[0] = 16'd100;  t_pred[0] = ramp(0, 7);
        t_coef[1] = {-16'sd1000, -16'sd1000};    t_dq[1] = 16'd100;  t_pred[1] = ramp(3, 8);
        // R1 rounding boundary: 3 -> 0, 4 -> 1 (left), -4 -> 0, -5 -> -1 (right)
        t_coef[2] = {16'd4, 16'd3};              t_dq[2] = 16'd1;    t_pred[2] = ramp(100, 1);
        t_coef[3] = {-16'sd5, -16'sd4};          t_dq[3] = 16'd1;    t_pred[3] = ramp(100, 1);
        // R1 zero dq leaves prediction untouched
        t_coef[4] = {16'h7fff, 16'h8000};        t_dq[4] = 16'd0;    t_pred[4] = ramp(17, 9);
        // R1 offset wraps to 16 bits: 32767*32767 -> offset -8192
        t_coef[5] = {16'h7fff, 16'h7fff};        t_dq[5] = 16'h7fff; t_pred[5] = ramp(250, 1);
        // R2 blocks differ in sign, so the column split is visible
        t_coef[6] = {-16'sd40, 16'd40};          t_dq[6] = 16'd8;    t_pred[6] = ramp(120, 0);
        // R3 negative dq with positive coefficient
        t_coef[7] = {16'd12, 16'd12};            t_dq[7] = -16'sd30; t_pred[7] = ramp(40, 3);
        lf = 32'h1234_5678;
        for (int i = 8; i < NT; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]} ^ (lf >> 7);
            t_coef[i] = {lf[15:6], 6'd0} ^ lf;
            t_dq[i]   = 16'(lf[27:20]);
            t_pred[i] = {8{lf ^ 32'h9e37_79b9 * 32'(i)}};
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int phase;
        int idx;
        int taken;
        bit acc;
        logic [255:0] pending;
        logic [255:0] shown;
        phase = 0; idx = 0; taken = 0; acc = 1'b0;
        pending = '0; shown = '0;

        repeat (3) @(negedge clk);
        // R8 during reset
        check(out_valid == 1'b0 && in_ready == 1'b1 && clr_dc == 2'b00, "R8 reset state",
              {out_valid, in_ready, clr_dc}, {1'b0, 1'b1, 2'b00});
        rst_n = 1'b1;

        for (int cyc = 0; cyc < 600 && taken < NT; cyc++) begin
            bit exp_ready;
            @(negedge clk);
            if (acc) begin
                in_valid = 1'b0;
                idx++;
            end
            out_ready = (cyc % 5 != 2) && (cyc % 7 != 4);
            if (!in_valid && idx < NT && (cyc % 3 != 1)) begin
                in_valid = 1'b1;
                dc_coef  = t_coef[idx];
                dq       = t_dq[idx];
                pred     = t_pred[idx];
            end
            #1;
            exp_ready = (phase == 0) || (phase == 2 && out_ready);
            check(in_ready == exp_ready, "R6 in_ready", 256'(in_ready), 256'(exp_ready));
            check(out_valid == (phase == 2), "R4 R5 R8 out_valid", 256'(out_valid),
                  256'(phase == 2));
            check(clr_dc == ((phase == 1) ? 2'b11 : 2'b00), "R7 clr_dc", 256'(clr_dc),
                  256'((phase == 1) ? 2'b11 : 2'b00));
            if (phase == 2)
                check(recon == shown, "R1 R2 R3 R5 recon", recon, shown);

            acc = in_valid && exp_ready;
            case (phase)
                0: if (acc) phase = 1;
                1: begin
                    shown = pending;
                    phase = 2;
                end
                2: if (out_ready) begin
                    taken++;
                    phase = acc ? 1 : 0;
                end
                default: phase = 0;
            endcase
            if (acc) pending = ref_recon(dc_coef, dq, pred);
        end

        // R3 directed: first pair must saturate to all 255, second to all 0
        check(ref_recon(t_coef[0], t_dq[0], t_pred[0]) == {32{8'hff}}, "R3 model high",
              ref_recon(t_coef[0], t_dq[0], t_pred[0]), {32{8'hff}});
        check(taken == NT, "R4 all pairs returned", 256'(taken), 256'(NT));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule